// File: doc/BRIEF.md
# Flag-Generating Byte/Word Arithmetic Unit

This block is the arithmetic core of a small 8-bit processor. An operation code selects one of eight functions: byte add, increment, decrement, compare, exclusive-or, accumulator complement, 16-bit pair add, and 16-bit pointer plus a signed byte offset. Each function produces its result and the next values of the four condition flags: zero, subtract, half-carry and carry. The half-carry and carry are taken at a bit position that depends on the operation. Each operation also has its own rule for which flags it sets, clears or passes through from the incoming flag vector.

The function logic is purely combinational. Two lanes do the work: a byte lane for the 8-bit operations and a word lane for the 16-bit ones. A thin registered wrapper captures the byte result, the word result and the flags on the clock edge where `strobe` is high. A two-state machine raises `fresh_q` for each cycle whose outputs came from the strobe of the cycle before.

State machine: `ST_QUIET` → `ST_FRESH` on a strobe; `ST_FRESH` → `ST_FRESH` on a further strobe; `ST_FRESH` → `ST_QUIET` when there is no strobe; `ST_QUIET` → `ST_QUIET` when there is no strobe. Reset enters `ST_QUIET`.

Top module: `flag_alu_reg`

## Requirements
- R1: Operation code 0 (byte add) gives res8 = (acc + opnd) mod 256. Flags are packed as bit 3 Z, bit 2 N, bit 1 H, bit 0 C. This operation sets Z when the result is zero, clears N, sets H on a carry out of bit 3 and sets C on a carry out of bit 7.
- R2: Operation code 1 (increment) gives res8 = (opnd + 1) mod 256. It sets Z from the result, clears N, sets H when the low nibble of opnd is 0xF, and passes C through from flags_in.
- R3: Operation code 2 (decrement) gives res8 = (opnd − 1) mod 256. It sets Z from the result, sets N, sets H when the low nibble of opnd is 0, and passes C through.
- R4: Operation code 3 (compare) leaves res8 equal to acc. It sets Z when acc equals opnd, sets N, sets H when the low nibble of acc is below that of opnd, and sets C when acc < opnd unsigned.
- R5: Operation code 4 (exclusive-or) gives res8 = acc XOR opnd. It sets Z from the result and clears N, H and C.
- R6: Operation code 5 (complement) gives res8 = NOT acc. It sets N and H and passes Z and C through.
- R7: Operation code 6 (pair add) gives res16 = (pair_x + pair_y) mod 65536. It clears N, passes Z through, sets H on a carry out of bit 11 and sets C on a carry out of bit 15.
- R8: Operation code 7 (offset add) gives res16 = pair_x plus opnd sign-extended, mod 65536. It forces Z and N to 0 and takes H and C from the carries out of bits 3 and 7 of the low-byte sum.
- R9: Codes 8 to 15 are unlisted. For these, the flags equal flags_in, res8 equals acc and res16 equals pair_x. Byte operations also give res16 = pair_x, and word operations give res8 = acc.
- R10: Outputs update on the edge where strobe is high and hold their values otherwise.
- R11: After reset, res8_q, res16_q, flags_q and fresh_q are all zero.
- R12: fresh_q is high in exactly those cycles that follow an edge with strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Capture the current result on this edge |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Second byte operand (also the signed offset) |
| pair_x | input | 16 | First 16-bit operand |
| pair_y | input | 16 | Second 16-bit operand |
| flags_in | input | 4 | Incoming flags {Z,N,H,C} |
| res8_q | output | 8 | Registered byte result |
| res16_q | output | 16 | Registered word result |
| flags_q | output | 4 | Registered next flags {Z,N,H,C} |
| fresh_q | output | 1 | High the cycle after a capture |

## Verification
The bench builds the block with its default widths: an 8-bit byte lane with nibble half-carry and a 16-bit word lane with its half-carry at bit 12. At these widths the exact carry boundaries are within reach: 0x0F+1, 0xFF+1, 0x0FFF+1, 0xFFFF+1, and a low-byte wrap under a negative or positive offset. The flag pass-through rules are driven with flags_in values that differ from what the operation would compute. This shows which flags each operation preserves. Back-to-back strobes and idle gaps exercise both transitions out of each state.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_INC   = 4'd1,
        OP_DEC   = 4'd2,
        OP_CMP   = 4'd3,
        OP_XOR   = 4'd4,
        OP_CPL   = 4'd5,
        OP_ADDW  = 4'd6,
        OP_SPOFF = 4'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

endpackage

// File: rtl/alu_byte_lane.sv
module alu_byte_lane
    import alu_flags_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [3:0]        op,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] opnd,
    input  flags_t            fin,
    output logic [BYTE_W-1:0] res,
    output flags_t            fout,
    output logic              hit
);
    localparam int NIB = BYTE_W / 2;

    logic [BYTE_W:0]   add_sum;
    logic [BYTE_W-1:0] add_tap;
    logic [BYTE_W:0]   inc_sum;
    logic [BYTE_W-1:0] inc_tap;
    logic [BYTE_W:0]   cmp_diff;
    logic [NIB:0]      cmp_nib;
    logic [NIB:0]      dec_nib;

    always_comb begin
        add_sum  = {1'b0, acc} + {1'b0, opnd};
        add_tap  = acc ^ opnd ^ add_sum[BYTE_W-1:0];
        inc_sum  = {1'b0, opnd} + 1'b1;
        inc_tap  = opnd ^ BYTE_W'(1) ^ inc_sum[BYTE_W-1:0];
        cmp_diff = {1'b0, acc} - {1'b0, opnd};
        cmp_nib  = {1'b0, acc[NIB-1:0]} - {1'b0, opnd[NIB-1:0]};
        dec_nib  = {1'b0, opnd[NIB-1:0]} - 1'b1;
    end

    always_comb begin
        res  = acc;
        fout = fin;
        hit  = 1'b1;
        case (op)
            OP_ADD: begin
                res  = add_sum[BYTE_W-1:0];
                fout = '{z: (add_sum[BYTE_W-1:0] == '0), n: 1'b0,
                         h: add_tap[NIB], c: add_sum[BYTE_W]};
            end
            OP_INC: begin
                res    = inc_sum[BYTE_W-1:0];
                fout.z = (inc_sum[BYTE_W-1:0] == '0);
                fout.n = 1'b0;
                fout.h = inc_tap[NIB];
            end
            OP_DEC: begin
                res    = opnd - 1'b1;
                fout.z = (opnd == BYTE_W'(1));
                fout.n = 1'b1;
                fout.h = dec_nib[NIB];
            end
            OP_CMP: begin
                fout = '{z: (cmp_diff[BYTE_W-1:0] == '0), n: 1'b1,
                         h: cmp_nib[NIB], c: cmp_diff[BYTE_W]};
            end
            OP_XOR: begin
                res  = acc ^ opnd;
                fout = '{z: ((acc ^ opnd) == '0), n: 1'b0, h: 1'b0, c: 1'b0};
            end
            OP_CPL: begin
                res    = ~acc;
                fout.n = 1'b1;
                fout.h = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end

    // R5: exclusive-or always leaves N, H and C clear
    always_comb begin
        if (op == OP_XOR)
            assert_xor_clear_R5: assert (!fout.n && !fout.h && !fout.c);
    end
endmodule

// File: rtl/alu_word_lane.sv
module alu_word_lane
    import alu_flags_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [3:0]        op,
    input  logic [WORD_W-1:0] pair_x,
    input  logic [WORD_W-1:0] pair_y,
    input  logic [BYTE_W-1:0] offs,
    input  flags_t            fin,
    output logic [WORD_W-1:0] res,
    output flags_t            fout,
    output logic              hit
);
    localparam int NIB   = BYTE_W / 2;
    localparam int HBIT  = WORD_W - NIB;
    localparam int EXT_W = WORD_W - BYTE_W;

    logic [WORD_W:0]   pair_sum;
    logic [WORD_W-1:0] pair_tap;
    logic [WORD_W-1:0] offs_ext;
    logic [WORD_W-1:0] offs_sum;
    logic [WORD_W-1:0] offs_tap;

    always_comb begin
        pair_sum = {1'b0, pair_x} + {1'b0, pair_y};
        pair_tap = pair_x ^ pair_y ^ pair_sum[WORD_W-1:0];
        offs_ext = {{EXT_W{offs[BYTE_W-1]}}, offs};
        offs_sum = pair_x + offs_ext;
        offs_tap = pair_x ^ offs_ext ^ offs_sum;
    end

    always_comb begin
        res  = pair_x;
        fout = fin;
        hit  = 1'b1;
        case (op)
            OP_ADDW: begin
                res    = pair_sum[WORD_W-1:0];
                fout.n = 1'b0;
                fout.h = pair_tap[HBIT];
                fout.c = pair_sum[WORD_W];
            end
            OP_SPOFF: begin
                res  = offs_sum;
                fout = '{z: 1'b0, n: 1'b0, h: offs_tap[NIB], c: offs_tap[BYTE_W]};
            end
            default: hit = 1'b0;
        endcase
    end

    // R8: offset add never reports zero or subtract
    always_comb begin
        if (op == OP_SPOFF)
            assert_spoff_zn_R8: assert (!fout.z && !fout.n);
    end
endmodule

// File: rtl/flag_alu_reg.sv
module flag_alu_reg
    import alu_flags_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [3:0]        op,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] opnd,
    input  logic [WORD_W-1:0] pair_x,
    input  logic [WORD_W-1:0] pair_y,
    input  logic [3:0]        flags_in,
    output logic [BYTE_W-1:0] res8_q,
    output logic [WORD_W-1:0] res16_q,
    output logic [3:0]        flags_q,
    output logic              fresh_q
);
    typedef enum logic {ST_QUIET, ST_FRESH} cap_state_e;

    cap_state_e        state, state_nx;
    flags_t            fin, f_byte, f_word, f_next;
    logic [BYTE_W-1:0] r_byte;
    logic [WORD_W-1:0] r_word;
    logic              hit_byte, hit_word;

    assign fin = flags_t'(flags_in);

    alu_byte_lane #(.BYTE_W(BYTE_W)) u_byte (
        .op(op), .acc(acc), .opnd(opnd), .fin(fin),
        .res(r_byte), .fout(f_byte), .hit(hit_byte)
    );

    alu_word_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_word (
        .op(op), .pair_x(pair_x), .pair_y(pair_y), .offs(opnd), .fin(fin),
        .res(r_word), .fout(f_word), .hit(hit_word)
    );

    always_comb begin
        if (hit_byte)      f_next = f_byte;
        else if (hit_word) f_next = f_word;
        else               f_next = fin;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET: if (strobe)  state_nx = ST_FRESH;
            ST_FRESH: if (!strobe) state_nx = ST_QUIET;
            default:               state_nx = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_QUIET;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res8_q  <= '0;
            res16_q <= '0;
            flags_q <= '0;
        end else if (strobe) begin
            res8_q  <= r_byte;
            res16_q <= r_word;
            flags_q <= f_next;
        end
    end

    always_comb fresh_q = (state == ST_FRESH);

    // R2, R3: increment and decrement keep the incoming carry
    assert_incdec_keep_c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && (op == OP_INC || op == OP_DEC) |=> flags_q[0] == $past(flags_in[0]));
    // R4: compare leaves the accumulator result untouched
    assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && op == OP_CMP |=> res8_q == $past(acc));
    // R6: complement sets N and H, keeps Z and C
    assert_cpl_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && op == OP_CPL |=> flags_q[2] && flags_q[1]
            && flags_q[3] == $past(flags_in[3]) && flags_q[0] == $past(flags_in[0]));
    // R9: unlisted codes pass flags through
    assert_unlisted_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && op[3] |=> flags_q == $past(flags_in));
    // R10: no strobe, no change
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(res8_q) && $stable(res16_q) && $stable(flags_q));
    // R12: fresh follows a strobe
    assert_fresh_R12: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> fresh_q);
endmodule

// File: tb/tb_flag_alu_reg.sv
module tb_flag_alu_reg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [3:0]  op = '0;
    logic [7:0]  acc = '0, opnd = '0;
    logic [15:0] pair_x = '0, pair_y = '0;
    logic [3:0]  flags_in = '0;
    logic [7:0]  res8_q;
    logic [15:0] res16_q;
    logic [3:0]  flags_q;
    logic        fresh_q;

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct {
        logic [7:0]  r8;
        logic [15:0] r16;
        logic [3:0]  f;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    flag_alu_reg dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .op(op), .acc(acc), .opnd(opnd),
        .pair_x(pair_x), .pair_y(pair_y), .flags_in(flags_in),
        .res8_q(res8_q), .res16_q(res16_q), .flags_q(flags_q), .fresh_q(fresh_q)
    );

    function automatic exp_t model(input int o, input int a, input int b,
                                   input int x, input int y, input logic [3:0] fi,
                                   input string tag);
        exp_t e;
        int s, off;
        logic z, n, h, c;
        {z, n, h, c} = fi;
        e.r8 = a[7:0]; e.r16 = x[15:0]; e.tag = tag;
        case (o)
            0: begin s = a + b; e.r8 = s[7:0]; z = (s % 256) == 0; n = 0;
                     h = ((a % 16) + (b % 16)) > 15; c = s > 255; end
            1: begin s = (b + 1) % 256; e.r8 = s[7:0]; z = s == 0; n = 0;
                     h = (b % 16) == 15; end
            2: begin s = (b + 255) % 256; e.r8 = s[7:0]; z = s == 0; n = 1;
                     h = (b % 16) == 0; end
            3: begin z = a == b; n = 1; h = (a % 16) < (b % 16); c = a < b; end
            4: begin s = a ^ b; e.r8 = s[7:0]; z = s == 0; n = 0; h = 0; c = 0; end
            5: begin s = 255 - a; e.r8 = s[7:0]; n = 1; h = 1; end
            6: begin s = x + y; e.r16 = s[15:0]; n = 0;
                     h = ((x % 4096) + (y % 4096)) > 4095; c = s > 65535; end
            7: begin off = (b >= 128) ? b - 256 : b; s = (x + off + 65536) % 65536;
                     e.r16 = s[15:0]; z = 0; n = 0;
                     h = ((x % 16) + (b % 16)) > 15; c = ((x % 256) + b) > 255; end
            default: ;
        endcase
        e.f = {z, n, h, c};
        return e;
    endfunction

    task automatic drive(input int o, input int a, input int b, input int x,
                         input int y, input logic [3:0] fi, input string tag);
        @(negedge clk);
        op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; pair_x = x[15:0]; pair_y = y[15:0];
        flags_in = fi; strobe = 1'b1;
        sb.push_back(model(o, a, b, x, y, fi, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            strobe = 1'b0;
            op = 4'd4; acc = 8'hFF; opnd = 8'h00; flags_in = 4'hF;
        end
    endtask

    task automatic check(input bit ok, input string msg, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", msg, act, expv);
        end
    endtask

    // monitor: compares every fresh result with the scoreboard head
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && fresh_q) begin
                if (sb.size() == 0) begin
                    check(0, "R12 unexpected fresh_q", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(res8_q == e.r8, {e.tag, " res8"}, res8_q, e.r8);
                    check(res16_q == e.r16, {e.tag, " res16"}, res16_q, e.r16);
                    check(flags_q == e.f, {e.tag, " flags"}, flags_q, e.f);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] h8;
        logic [3:0] hf;
        repeat (3) @(posedge clk);
        #1;
        check(res8_q == 0 && res16_q == 0 && flags_q == 0 && fresh_q == 0,
              "R11 reset state", {res8_q, flags_q, 3'b0, fresh_q}, 0);
        @(negedge clk); rst_n = 1'b1;

        drive(0, 8'h3A, 8'hC6, 16'h1234, 0, 4'h0, "R1 add wrap");
        drive(0, 8'h0F, 8'h01, 0, 0, 4'hF, "R1 add half");
        drive(1, 0, 8'hFF, 0, 0, 4'h1, "R2 inc wrap keep C");
        drive(1, 0, 8'h0F, 0, 0, 4'h0, "R2 inc half");
        drive(2, 0, 8'h10, 0, 0, 4'h1, "R3 dec borrow");
        drive(2, 0, 8'h01, 0, 0, 4'h0, "R3 dec zero");
        drive(3, 8'h42, 8'h42, 0, 0, 4'h0, "R4 cmp equal");
        drive(3, 8'h10, 8'h01, 0, 0, 4'h0, "R4 cmp half");
        drive(3, 8'h05, 8'h20, 0, 0, 4'h0, "R4 cmp below");
        idle(2);
        drive(4, 8'h77, 8'h77, 0, 0, 4'hF, "R5 xor self");
        drive(4, 8'h5A, 8'h0F, 0, 0, 4'hF, "R5 xor");
        drive(5, 8'h3C, 0, 0, 0, 4'h9, "R6 cpl keep ZC");
        drive(5, 8'hFF, 0, 0, 0, 4'h0, "R6 cpl zero res");
        drive(6, 0, 0, 16'h0FFF, 16'h0001, 4'h8, "R7 pair half keep Z");
        drive(6, 0, 0, 16'hFFFF, 16'h0001, 4'h0, "R7 pair wrap");
        drive(6, 0, 0, 16'h1234, 16'h0101, 4'h7, "R7 pair plain");
        drive(7, 0, 8'h08, 16'hFFF8, 0, 4'hF, "R8 offset wrap");
        drive(7, 0, 8'hFF, 16'h0000, 0, 4'hF, "R8 offset neg");
        drive(7, 0, 8'h80, 16'h0180, 0, 4'h0, "R8 offset neg carry");
        drive(9, 8'h21, 8'h99, 16'hBEEF, 16'h1111, 4'hA, "R9 unlisted");
        drive(15, 8'h00, 8'hFF, 16'hFFFF, 16'hFFFF, 4'h5, "R9 unlisted top");
        idle(1);
        // R10: idle inputs would change the result if captured
        h8 = res8_q; hf = flags_q;
        idle(3);
        #1;
        check(res8_q == h8, "R10 hold res8", res8_q, h8);
        check(flags_q == hf, "R10 hold flags", flags_q, hf);
        check(fresh_q == 0, "R12 fresh low when idle", fresh_q, 0);
        check(sb.size() == 0, "R12 all results seen", sb.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule